// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Routing

This block collects a bank of level-sensitive interrupt sources and reduces them to one combined request for an upstream controller. Each clock it captures every source into a raw level register. A programmable enable mask selects which captured levels count toward the combined request. That request is placed on the top output line.

A contiguous band of sources can also be routed straight through to their own output lines. This lets an upstream controller see those sources individually. A separate routing-enable register controls this band. Its set port drops any bit that lies outside the band.

Software reaches the block through a simple select/write register port with 32-bit data. A register is picked by its word index, which is the byte address shifted right by two, inside a 4096-byte window. Read data appears combinationally in the same cycle. A write takes effect at the clock edge on which the select and write strobes are both high.

Top module: `sec_irq_agg`

## Requirements
- R1: A synchronous active-low reset clears the captured levels, the enable mask and the routing enable. While reset is held and right after it, every output line is low and every register reads zero.
- R2: The sources are captured into a raw level register on every clock. Reading word index 1 returns that register, so a change at the inputs shows up in the following cycle.
- R3: Reading word index 0 returns the bitwise AND of the raw level register and the enable mask.
- R4: A write to word index 2 ORs the write data into the enable mask. A write to word index 3 clears each mask bit that is 1 in the write data. Reading word index 2 returns the mask.
- R5: Output line 31 is high exactly when the raw level ANDed with the enable mask is nonzero.
- R6: A write of any nonzero value to word index 4 sets mask bit 0. A write of any nonzero value to word index 5 clears mask bit 0. A write of zero to either index changes nothing. Reading word index 4 returns raw level bit 0 in bit position 0, with all other bits zero.
- R7: A write to word index 8 ORs in only bits 21 through 30 of the write data (data AND 0x7FE00000) into the routing enable. A write to word index 9 clears each routing-enable bit that is 1 in the write data. Reading word index 8 returns the routing enable.
- R8: For each line i from 21 to 30, output i equals raw level bit i while routing-enable bit i is set, and is low otherwise. It drops low on the clock edge that clears the enable. Output lines 0 through 20 are always low.
- R9: Reads of word indices 3, 5, 6, 7, 9 and anything above 9 return zero, and writes to indices 0, 1, 6, 7 and above 9 change no state. The two low byte-address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe, qualified by sel |
| addr | input | 12 | Byte address within the 4096-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the access cycle while sel is high |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| irq_out | output | 32 | Routed lines 21..30 and combined request on line 31 |

## Verification
The hardest case to reach from the ports is a routed line that toggles while its routing enable is changing. This includes a set attempt whose data lies outside the band, a clear in the same cycle as an input edge, and a set with bits 31 or 0..20 included. The stimulus interleaves random writes to the routing set and clear indices with random source patterns on every cycle, and a bench model predicts each output line. Directed steps add all-ones and zero writes to the soft-bit and routing ports, and writes to unused indices followed by read-back of every register.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;
   // Word indices (byte offset >> 2) decoded by the register port
   localparam int unsigned WIX_STATUS   = 0;
   localparam int unsigned WIX_RAW      = 1;
   localparam int unsigned WIX_EN_SET   = 2;
   localparam int unsigned WIX_EN_CLR   = 3;
   localparam int unsigned WIX_SOFT_SET = 4;
   localparam int unsigned WIX_SOFT_CLR = 5;
   localparam int unsigned WIX_PT_SET   = 8;
   localparam int unsigned WIX_PT_CLR   = 9;

   // Mask bit controlled by the soft set/clear indices
   localparam int unsigned SOFT_BIT = 0;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_EN_OR,
      OP_EN_CLR,
      OP_SOFT_SET,
      OP_SOFT_CLR,
      OP_PT_OR,
      OP_PT_CLR
   } wr_op_e;
endpackage

// File: rtl/sec_irq_sampler.sv
module sec_irq_sampler #(
   parameter int N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   output logic [N_SRC-1:0] level
);
   always_ff @(posedge clk) begin
      if (!rst_n) level <= '0;
      else        level <= src;
   end
endmodule

// File: rtl/sec_irq_regfile.sv
module sec_irq_regfile
   import sec_irq_pkg::*;
#(
   parameter int N_SRC   = 32,
   parameter int IDX_W   = 10,
   parameter int PASS_LO = 21,
   parameter int PASS_HI = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [N_SRC-1:0] wdata,
   output logic [N_SRC-1:0] en_mask,
   output logic [N_SRC-1:0] pass_en
);
   logic [N_SRC-1:0] pass_allow;
   wr_op_e           op;

   for (genvar g = 0; g < N_SRC; g++) begin : g_allow
      if (g >= PASS_LO && g <= PASS_HI) begin : g_in
         assign pass_allow[g] = 1'b1;
      end else begin : g_out
         assign pass_allow[g] = 1'b0;
      end
   end

   always_comb begin
      op = OP_NONE;
      if (wr_en) begin
         case (idx)
            IDX_W'(WIX_EN_SET):   op = OP_EN_OR;
            IDX_W'(WIX_EN_CLR):   op = OP_EN_CLR;
            IDX_W'(WIX_SOFT_SET): op = OP_SOFT_SET;
            IDX_W'(WIX_SOFT_CLR): op = OP_SOFT_CLR;
            IDX_W'(WIX_PT_SET):   op = OP_PT_OR;
            IDX_W'(WIX_PT_CLR):   op = OP_PT_CLR;
            default:              op = OP_NONE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_mask <= '0;
         pass_en <= '0;
      end else begin
         case (op)
            OP_EN_OR:    en_mask <= en_mask | wdata;
            OP_EN_CLR:   en_mask <= en_mask & ~wdata;
            OP_SOFT_SET: if (|wdata) en_mask[SOFT_BIT] <= 1'b1;
            OP_SOFT_CLR: if (|wdata) en_mask[SOFT_BIT] <= 1'b0;
            OP_PT_OR:    pass_en <= pass_en | (wdata & pass_allow);
            OP_PT_CLR:   pass_en <= pass_en & ~wdata;
            default:     ;
         endcase
      end
   end
endmodule

// File: rtl/sec_irq_readmux.sv
module sec_irq_readmux
   import sec_irq_pkg::*;
#(
   parameter int N_SRC = 32,
   parameter int IDX_W = 10
) (
   input  logic             rd_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [N_SRC-1:0] level,
   input  logic [N_SRC-1:0] en_mask,
   input  logic [N_SRC-1:0] pass_en,
   output logic [N_SRC-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (idx)
            IDX_W'(WIX_STATUS):   rdata = level & en_mask;
            IDX_W'(WIX_RAW):      rdata = level;
            IDX_W'(WIX_EN_SET):   rdata = en_mask;
            IDX_W'(WIX_SOFT_SET): rdata[SOFT_BIT] = level[SOFT_BIT];
            IDX_W'(WIX_PT_SET):   rdata = pass_en;
            default:              rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route #(
   parameter int N_SRC     = 32,
   parameter int PASS_LO   = 21,
   parameter int PASS_HI   = 30,
   parameter int COMB_LINE = 31
) (
   input  logic [N_SRC-1:0] level,
   input  logic [N_SRC-1:0] en_mask,
   input  logic [N_SRC-1:0] pass_en,
   output logic [N_SRC-1:0] irq_out
);
   logic any_pending;
   assign any_pending = |(level & en_mask);

   for (genvar g = 0; g < N_SRC; g++) begin : g_line
      if (g == COMB_LINE) begin : g_comb
         assign irq_out[g] = any_pending;
      end else if (g >= PASS_LO && g <= PASS_HI) begin : g_pass
         assign irq_out[g] = pass_en[g] & level[g];
      end else begin : g_idle
         assign irq_out[g] = 1'b0;
      end
   end

   logic unused_route;
   assign unused_route = &{1'b0, pass_en};
endmodule

// File: rtl/sec_irq_agg.sv
module sec_irq_agg #(
   parameter int N_SRC     = 32,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int PASS_LO   = 21,
   parameter int PASS_HI   = 30,
   parameter int COMB_LINE = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_SRC-1:0]  irq_in,
   output logic [N_SRC-1:0]  irq_out
);
   localparam int IDX_W = ADDR_W - 2;

   if (DATA_W != N_SRC) begin : g_bad_width
      $error("sec_irq_agg: DATA_W must equal N_SRC");
   end
   if (IDX_W < 4) begin : g_bad_addr
      $error("sec_irq_agg: ADDR_W too small to decode word index 9");
   end
   if (PASS_LO < 1 || PASS_HI < PASS_LO || PASS_HI >= COMB_LINE) begin : g_bad_band
      $error("sec_irq_agg: routed band must sit between bit 0 and the combined line");
   end
   if (COMB_LINE >= N_SRC) begin : g_bad_comb
      $error("sec_irq_agg: combined line out of range");
   end

   logic [IDX_W-1:0] word_idx;
   logic             wr_en;
   logic             rd_en;
   logic [N_SRC-1:0] level;
   logic [N_SRC-1:0] en_mask;
   logic [N_SRC-1:0] pass_en;

   assign word_idx = addr[ADDR_W-1:2];
   assign wr_en    = sel & wr;
   assign rd_en    = sel & ~wr;

   logic unused_addr;
   assign unused_addr = &{1'b0, addr[1:0]};

   sec_irq_sampler #(.N_SRC(N_SRC)) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (irq_in),
      .level (level)
   );

   sec_irq_regfile #(
      .N_SRC(N_SRC), .IDX_W(IDX_W), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .idx     (word_idx),
      .wdata   (wdata),
      .en_mask (en_mask),
      .pass_en (pass_en)
   );

   sec_irq_readmux #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_rmux (
      .rd_en   (rd_en),
      .idx     (word_idx),
      .level   (level),
      .en_mask (en_mask),
      .pass_en (pass_en),
      .rdata   (rdata)
   );

   sec_irq_route #(
      .N_SRC(N_SRC), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI), .COMB_LINE(COMB_LINE)
   ) u_route (
      .level   (level),
      .en_mask (en_mask),
      .pass_en (pass_en),
      .irq_out (irq_out)
   );
endmodule

// File: rtl/sec_irq_chk.sv
module sec_irq_chk #(
   parameter int N_SRC     = 32,
   parameter int ADDR_W    = 12,
   parameter int PASS_LO   = 21,
   parameter int PASS_HI   = 30,
   parameter int COMB_LINE = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              wr,
   input logic [ADDR_W-1:0] addr,
   input logic [N_SRC-1:0]  wdata,
   input logic [N_SRC-1:0]  rdata,
   input logic [N_SRC-1:0]  irq_in,
   input logic [N_SRC-1:0]  irq_out,
   input logic [N_SRC-1:0]  level,
   input logic [N_SRC-1:0]  en_mask,
   input logic [N_SRC-1:0]  pass_en
);
   localparam int IDX_W = ADDR_W - 2;
   logic [IDX_W-1:0] ix;
   assign ix = addr[ADDR_W-1:2];

   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> level == $past(irq_in));

   a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && ix == IDX_W'(2)) |=> ((en_mask & $past(wdata)) == $past(wdata)));

   a_r4_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && ix == IDX_W'(3)) |=> ((en_mask & $past(wdata)) == '0));

   a_r5_comb_vs_status: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wr && ix == IDX_W'(0)) |-> (irq_out[COMB_LINE] == (rdata != '0)));

   a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && ix == IDX_W'(4) && wdata != '0) |=> en_mask[0]);

   a_r7_band_only: assert property (@(posedge clk) disable iff (!rst_n)
      pass_en[PASS_LO-1:0] == '0 && pass_en[N_SRC-1:PASS_HI+1] == '0);

   a_r7_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && ix == IDX_W'(9)) |=> ((pass_en & $past(wdata)) == '0));

   a_r8_low_lines: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[PASS_LO-1:0] == '0);

   for (genvar k = PASS_LO; k <= PASS_HI; k++) begin : g_follow
      a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && pass_en[k]) |-> irq_out[k] == $past(irq_in[k]));
      a_r8_off: assert property (@(posedge clk) disable iff (!rst_n)
         !pass_en[k] |-> !irq_out[k]);
   end

   a_r9_high_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wr && ix > IDX_W'(9)) |-> rdata == '0);
endmodule

bind sec_irq_agg sec_irq_chk #(
   .N_SRC(N_SRC), .ADDR_W(ADDR_W), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI), .COMB_LINE(COMB_LINE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
   .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out),
   .level(level), .en_mask(en_mask), .pass_en(pass_en)
);

// File: tb/test_sec_irq_agg.sv
module test_sec_irq_agg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] irq_in = '0;
   logic [31:0] irq_out;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // bench model
   logic [31:0] m_lvl = '0, m_mask = '0, m_pass = '0;

   always #2 clk = ~clk;

   sec_irq_agg i_sec_irq_agg (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out)
   );

   function automatic logic [31:0] exp_read(input int unsigned ix);
      case (ix)
         0: return m_lvl & m_mask;
         1: return m_lvl;
         2: return m_mask;
         4: return {31'b0, m_lvl[0]};
         8: return m_pass;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string read_tag(input int unsigned ix);
      case (ix)
         0: return "R3";
         1: return "R2";
         2: return "R4";
         4: return "R6";
         8: return "R7";
         default: return "R9";
      endcase
   endfunction

   function automatic logic [31:0] exp_out();
      logic [31:0] o = '0;
      for (int i = 21; i <= 30; i++) o[i] = m_pass[i] & m_lvl[i];
      o[31] = |(m_lvl & m_mask);
      return o;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_write(input int unsigned ix, input logic [31:0] d);
      case (ix)
         2: m_mask = m_mask | d;
         3: m_mask = m_mask & ~d;
         4: if (d != 0) m_mask[0] = 1'b1;
         5: if (d != 0) m_mask[0] = 1'b0;
         8: m_pass = m_pass | (d & 32'h7FE0_0000);
         9: m_pass = m_pass & ~d;
         default: ;
      endcase
   endtask

   // one bus cycle: drive at negedge, check before the edge, update model at the edge
   task automatic step(input logic [31:0] src, input bit do_sel, input bit do_wr,
                       input int unsigned ix, input logic [31:0] d);
      @(negedge clk);
      irq_in = src;
      sel    = do_sel;
      wr     = do_wr;
      addr   = {ix[9:0], 2'($urandom_range(0, 3))};
      wdata  = d;
      #1;
      check("R5/R8 lines", irq_out, exp_out());
      if (do_sel && !do_wr) check(read_tag(ix), rdata, exp_read(ix));
      @(posedge clk);
      if (do_sel && do_wr) model_write(ix, d);
      m_lvl = src;
   endtask

   task automatic rd(input logic [31:0] src, input int unsigned ix);
      step(src, 1'b1, 1'b0, ix, 32'h0);
   endtask

   task automatic wrt(input logic [31:0] src, input int unsigned ix, input logic [31:0] d);
      step(src, 1'b1, 1'b1, ix, d);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R1: hold reset with busy inputs, then check everything is zero
      irq_in = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 out in reset", irq_out, 32'h0);
      irq_in = 32'h0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_lvl = '0; m_mask = '0; m_pass = '0;
      check("R1 out after reset", irq_out, 32'h0);
      for (int k = 0; k < 10; k++) rd(32'h0, k);

      // R2 one cycle latency
      step(32'hA5A5_0F0F, 1'b0, 1'b0, 0, 0);
      rd(32'hA5A5_0F0F, 1);
      check("R2 raw const", rdata, 32'hA5A5_0F0F);

      // R4 set / clear
      wrt(32'h0, 2, 32'h0000_00F0);
      wrt(32'h0, 2, 32'h0000_0F00);
      wrt(32'h0, 3, 32'h0000_0030);
      rd(32'h0000_0100, 2);
      check("R4 mask const", rdata, 32'h0000_0FC0);
      // R5 combined line follows level&mask
      step(32'h0000_0100, 1'b0, 1'b0, 0, 0);
      check("R5 comb high", {31'b0, irq_out[31]}, 32'h1);
      rd(32'h0000_0010, 0);

      // R6 soft bit: zero writes ignored, nonzero sets/clears
      wrt(32'h1, 4, 32'h0);
      rd(32'h1, 2);
      wrt(32'h1, 4, 32'h8000_0000);
      rd(32'h1, 4);
      check("R6 soft read", rdata, 32'h1);
      rd(32'h1, 2);
      wrt(32'h1, 5, 32'h0);
      rd(32'h1, 2);
      wrt(32'h1, 5, 32'h4);
      rd(32'h1, 2);

      // R7 band filter on set, clear, read back
      wrt(32'hFFFF_FFFF, 8, 32'hFFFF_FFFF);
      rd(32'hFFFF_FFFF, 8);
      check("R7 band const", rdata, 32'h7FE0_0000);
      // R8 clear drops the line at the next edge
      wrt(32'hFFFF_FFFF, 9, 32'h0020_0000);
      step(32'hFFFF_FFFF, 1'b0, 1'b0, 0, 0);
      check("R8 drop line21", {31'b0, irq_out[21]}, 32'h0);

      // R9 unused indices: no state change, read zero
      wrt(32'h0, 6, 32'hFFFF_FFFF);
      wrt(32'h0, 0, 32'hFFFF_FFFF);
      wrt(32'h0, 1, 32'hFFFF_FFFF);
      wrt(32'h0, 700, 32'hFFFF_FFFF);
      rd(32'h0, 2); rd(32'h0, 8); rd(32'h0, 3); rd(32'h0, 5);
      rd(32'h0, 9); rd(32'h0, 7); rd(32'h0, 1023);

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         int unsigned pick;
         int unsigned ix;
         logic [31:0] src;
         logic [31:0] d;
         pick = $urandom_range(0, 9);
         ix   = (pick == 9) ? $urandom_range(10, 1023) : $urandom_range(0, 9);
         src  = $urandom();
         if ($urandom_range(0, 3) == 0) src = src & 32'h7FE0_0001;
         d    = $urandom();
         if ($urandom_range(0, 4) == 0) d = 32'h0;
         case ($urandom_range(0, 2))
            0: wrt(src, ix, d);
            1: rd(src, ix);
            default: step(src, 1'b0, 1'b0, ix, d);
         endcase
      end

      // R1 reset again clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      irq_in = '0;
      m_lvl = '0; m_mask = '0; m_pass = '0;
      check("R1 out after second reset", irq_out, 32'h0);
      rd(32'h0, 2);
      rd(32'h0, 8);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule